// File: doc/BRIEF.md
# DRAM Output Driver Impedance Adjuster

This block sits on the device side of a DDR2-style memory and handles the off-chip-driver calibration field carried by an extended mode register write. The 3-bit field puts the data outputs into forced-high drive, forced-low drive or adjust mode. It can also leave calibration, or reload the factory default strength. In adjust mode the controller sends a 4-bit command serially over four beats on the DQ lane. That command moves two independent pull-up and pull-down strength steps up or down.

Each strength step is a saturating counter with 16 positions. The block also reports whether the default output characteristics still hold. They do not hold when half drive strength is selected, or once adjust mode has been entered since the last default load. Analog driver behaviour, pad timing and the other mode register fields are handled elsewhere.

Top module: `ocd_adjuster`

## Requirements
- R1: After reset, both strength steps equal the default step (8), no forced drive is active, all three drive levels are 0 and `dflt_ok_o` is 1.
- R2: An EMRS write with field 001 gives drive-high mode, one clock edge later: `drv_force_o`=1, `dq_lvl_o`=1, `dqs_lvl_o`=1, `dqs_n_lvl_o`=0. Field 010 gives drive-low mode: `drv_force_o`=1, `dq_lvl_o`=0, `dqs_lvl_o`=0, `dqs_n_lvl_o`=1. `dq_lvl_o` and `dqs_n_lvl_o` are never both 1.
- R3: Field 000 leaves calibration. Forced drive stops and all levels return to 0, while both strength steps keep their values. While a forced drive mode is active and no EMRS write occurs, the steps do not change.
- R4: Field 111 loads both steps with the default step (8), sets the default flag and returns the block to idle.
- R5: Fields 011, 101 and 110 are reserved. They leave the mode, the drive outputs and the strength steps unchanged.
- R6: Adjust mode is entered with field 100. A capture starts when `cap_start_i` is high at a clock edge. Beat DT0 is sampled at that edge and DT1 to DT3 at the next three edges. The value of a beat is the OR of the four `dq_i` bits. The steps change at the edge after the DT3 edge, which is the fifth edge counting the start edge, and not before it.
- R7: Codes are written DT0 DT1 DT2 DT3. Code 0001 increments pull-up, 0010 decrements pull-up, 0100 increments pull-down, 1000 decrements pull-down, and 0000 changes nothing. A step moves by at most one per clock edge, except on an EMRS write.
- R8: Code 0101 increments both steps, 0110 decrements pull-up and increments pull-down, 1001 increments pull-up and decrements pull-down, and 1010 decrements both. Every other code is a no-operation.
- R9: The steps saturate. An increment at 15 and a decrement at 0 have no effect.
- R10: `dflt_ok_o` = (default flag) AND NOT (half strength). The half-strength bit is latched from `emrs_half_i` on every EMRS write. Entering adjust mode clears the default flag, and field 111 or reset sets it. The flag falls only as a result of an EMRS write.
- R11: A capture strobe is ignored outside adjust mode and while a capture is in progress. Any EMRS write aborts a capture in progress, so that capture changes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emrs_we_i | input | 1 | Extended mode register write strobe |
| emrs_ocd_i | input | 3 | Driver calibration field of the write |
| emrs_half_i | input | 1 | Half drive strength select of the write |
| cap_start_i | input | 1 | Starts a 4-beat code capture in adjust mode |
| dq_i | input | DQ_W | DQ lane carrying the serial code |
| pu_step_o | output | STEP_W | Pull-up strength step |
| pd_step_o | output | STEP_W | Pull-down strength step |
| drv_force_o | output | 1 | A forced drive mode is active |
| dq_lvl_o | output | 1 | Forced level for DQ |
| dqs_lvl_o | output | 1 | Forced level for true DQS |
| dqs_n_lvl_o | output | 1 | Forced level for complementary DQS |
| dflt_ok_o | output | 1 | Default driver characteristics apply |

## Verification
Some properties are checked on every cycle:
- the two drive levels are never both 1;
- a step never wraps across its ends;
- a step moves by at most one between EMRS writes;
- the steps stay frozen during forced drive;
- a reserved field leaves the drive outputs alone;
- the default flag falls only after a write, and is held low after a half-strength write.

The exact decode of each 4-bit code, the edge on which an update lands, and the OR of the DQ lanes can only be shown by the bench's scenarios. The same holds for saturation after long runs, aborted and re-strobed captures, and the retention of values across exit and reserved writes.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  localparam int OCD_BEATS = 4;

  typedef enum logic [1:0] {
    OCD_IDLE   = 2'd0,
    OCD_DRV_HI = 2'd1,
    OCD_DRV_LO = 2'd2,
    OCD_ADJ    = 2'd3
  } ocd_mode_e;

  localparam logic [2:0] FLD_EXIT = 3'b000;
  localparam logic [2:0] FLD_DRV1 = 3'b001;
  localparam logic [2:0] FLD_DRV0 = 3'b010;
  localparam logic [2:0] FLD_ADJ  = 3'b100;
  localparam logic [2:0] FLD_DFLT = 3'b111;

  typedef struct packed {
    logic up_inc;
    logic up_dec;
    logic dn_inc;
    logic dn_dec;
  } step_cmd_t;

  // code bit 3 = DT0 ... bit 0 = DT3
  function automatic step_cmd_t decode_code(input logic [OCD_BEATS-1:0] c);
    step_cmd_t r;
    r = '0;
    unique case (c)
      4'b0001: r.up_inc = 1'b1;
      4'b0010: r.up_dec = 1'b1;
      4'b0100: r.dn_inc = 1'b1;
      4'b1000: r.dn_dec = 1'b1;
      4'b0101: begin r.up_inc = 1'b1; r.dn_inc = 1'b1; end
      4'b0110: begin r.up_dec = 1'b1; r.dn_inc = 1'b1; end
      4'b1001: begin r.up_inc = 1'b1; r.dn_dec = 1'b1; end
      4'b1010: begin r.up_dec = 1'b1; r.dn_dec = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocd_mode_ctl.sv
module ocd_mode_ctl
  import ocd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      fld_i,
  input  logic            half_i,
  output ocd_mode_e       mode_o,
  output logic            dflt_load_o,
  output logic            dflt_ok_o
);

  ocd_mode_e mode_q;
  logic      dflt_q;
  logic      half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OCD_IDLE;
      dflt_q <= 1'b1;
      half_q <= 1'b0;
    end else if (we_i) begin
      half_q <= half_i;
      case (fld_i)
        FLD_EXIT: mode_q <= OCD_IDLE;
        FLD_DRV1: mode_q <= OCD_DRV_HI;
        FLD_DRV0: mode_q <= OCD_DRV_LO;
        FLD_ADJ: begin
          mode_q <= OCD_ADJ;
          dflt_q <= 1'b0;
        end
        FLD_DFLT: begin
          mode_q <= OCD_IDLE;
          dflt_q <= 1'b1;
        end
        default: ; // reserved: hold
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign dflt_load_o = we_i && (fld_i == FLD_DFLT);
  assign dflt_ok_o   = dflt_q && !half_q;

endmodule

// File: rtl/ocd_burst_cap.sv
module ocd_burst_cap #(
  parameter int BEATS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             beat_i,
  output logic [BEATS-1:0] code_o,
  output logic             done_o
);

  localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [BEATS-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        sh_q <= {sh_q[BEATS-2:0], beat_i};
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else if (en_i && start_i) begin
        sh_q   <= {sh_q[BEATS-2:0], beat_i};
        cnt_q  <= CNT_W'(1);
        busy_q <= 1'b1;
      end
    end
  end

  assign code_o = sh_q;
  assign done_o = done_q;

endmodule

// File: rtl/ocd_step_ctr.sv
module ocd_step_ctr #(
  parameter int W   = 4,
  parameter int DEF = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] step_o
);

  localparam logic [W-1:0] MAX_V = '1;
  localparam logic [W-1:0] DEF_V = W'(DEF);

  logic [W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= DEF_V;
    end else if (load_i) begin
      step_q <= DEF_V;
    end else if (inc_i && step_q != MAX_V) begin
      step_q <= step_q + W'(1);
    end else if (dec_i && step_q != '0) begin
      step_q <= step_q - W'(1);
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/ocd_adjuster.sv
module ocd_adjuster
  import ocd_pkg::*;
#(
  parameter int STEP_W   = 4,
  parameter int DEF_STEP = 8,
  parameter int DQ_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emrs_we_i,
  input  logic [2:0]        emrs_ocd_i,
  input  logic              emrs_half_i,
  input  logic              cap_start_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [STEP_W-1:0] pu_step_o,
  output logic [STEP_W-1:0] pd_step_o,
  output logic              drv_force_o,
  output logic              dq_lvl_o,
  output logic              dqs_lvl_o,
  output logic              dqs_n_lvl_o,
  output logic              dflt_ok_o
);

  localparam int N_CTR = 2; // 0: pull-up, 1: pull-down

  ocd_mode_e            mode;
  logic                 dflt_load;
  logic [OCD_BEATS-1:0] code;
  logic                 code_done;
  step_cmd_t            cmd;
  logic [N_CTR-1:0]     ctr_inc, ctr_dec;
  logic [STEP_W-1:0]    step [N_CTR];

  ocd_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (emrs_we_i),
    .fld_i       (emrs_ocd_i),
    .half_i      (emrs_half_i),
    .mode_o      (mode),
    .dflt_load_o (dflt_load),
    .dflt_ok_o   (dflt_ok_o)
  );

  ocd_burst_cap #(.BEATS(OCD_BEATS)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode == OCD_ADJ),
    .abort_i (emrs_we_i),
    .start_i (cap_start_i),
    .beat_i  (|dq_i),
    .code_o  (code),
    .done_o  (code_done)
  );

  always_comb begin
    cmd        = code_done ? decode_code(code) : '0;
    ctr_inc[0] = cmd.up_inc;
    ctr_dec[0] = cmd.up_dec;
    ctr_inc[1] = cmd.dn_inc;
    ctr_dec[1] = cmd.dn_dec;
  end

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    ocd_step_ctr #(.W(STEP_W), .DEF(DEF_STEP)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (dflt_load),
      .inc_i  (ctr_inc[g]),
      .dec_i  (ctr_dec[g]),
      .step_o (step[g])
    );
  end

  assign pu_step_o   = step[0];
  assign pd_step_o   = step[1];
  assign drv_force_o = (mode == OCD_DRV_HI) || (mode == OCD_DRV_LO);
  assign dq_lvl_o    = (mode == OCD_DRV_HI);
  assign dqs_lvl_o   = (mode == OCD_DRV_HI);
  assign dqs_n_lvl_o = (mode == OCD_DRV_LO);

endmodule

// File: rtl/ocd_adjuster_chk.sv
module ocd_adjuster_chk #(
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              emrs_we_i,
  input logic [2:0]        emrs_ocd_i,
  input logic              emrs_half_i,
  input logic [STEP_W-1:0] pu_step_o,
  input logic [STEP_W-1:0] pd_step_o,
  input logic              drv_force_o,
  input logic              dq_lvl_o,
  input logic              dqs_n_lvl_o,
  input logic              dflt_ok_o
);

  localparam logic [STEP_W-1:0] MAX_V = '1;
  localparam logic [STEP_W-1:0] ONE   = STEP_W'(1);

  logic rsv_wr;
  assign rsv_wr = emrs_we_i &&
                  (emrs_ocd_i == 3'b011 || emrs_ocd_i == 3'b101 || emrs_ocd_i == 3'b110);

  assert_lvl_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_lvl_o && dqs_n_lvl_o));

  assert_force_lvl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_force_o == (dq_lvl_o || dqs_n_lvl_o));

  assert_frozen_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_force_o && !emrs_we_i) |=> ($stable(pu_step_o) && $stable(pd_step_o)));

  assert_rsv_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_wr |=> ($stable(drv_force_o) && $stable(dq_lvl_o) && $stable(dqs_n_lvl_o)));

  assert_pu_one_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(emrs_we_i) |-> ((pu_step_o - $past(pu_step_o)) == '0 ||
                           (pu_step_o - $past(pu_step_o)) == ONE ||
                           ($past(pu_step_o) - pu_step_o) == ONE));

  assert_pd_one_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(emrs_we_i) |-> ((pd_step_o - $past(pd_step_o)) == '0 ||
                           (pd_step_o - $past(pd_step_o)) == ONE ||
                           ($past(pd_step_o) - pd_step_o) == ONE));

  assert_pu_no_wrap_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pu_step_o) == MAX_V) |-> (pu_step_o != '0));

  assert_pu_no_wrap_bot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pu_step_o) == '0) |-> (pu_step_o != MAX_V));

  assert_pd_no_wrap_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_step_o) == MAX_V) |-> (pd_step_o != '0));

  assert_pd_no_wrap_bot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_step_o) == '0) |-> (pd_step_o != MAX_V));

  assert_dflt_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dflt_ok_o) |-> $past(emrs_we_i));

  assert_half_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emrs_we_i && emrs_half_i) |=> !dflt_ok_o);

endmodule

bind ocd_adjuster ocd_adjuster_chk #(.STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .emrs_we_i   (emrs_we_i),
  .emrs_ocd_i  (emrs_ocd_i),
  .emrs_half_i (emrs_half_i),
  .pu_step_o   (pu_step_o),
  .pd_step_o   (pd_step_o),
  .drv_force_o (drv_force_o),
  .dq_lvl_o    (dq_lvl_o),
  .dqs_n_lvl_o (dqs_n_lvl_o),
  .dflt_ok_o   (dflt_ok_o)
);

// File: tb/ocd_adjuster_tb.sv
module ocd_adjuster_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       emrs_we_i = 1'b0;
  logic [2:0] emrs_ocd_i = 3'b000;
  logic       emrs_half_i = 1'b0;
  logic       cap_start_i = 1'b0;
  logic [3:0] dq_i = 4'b0;
  logic [3:0] pu_step_o, pd_step_o;
  logic       drv_force_o, dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o, dflt_ok_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10ns clk = ~clk; // 50 MHz

  ocd_adjuster u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .emrs_we_i   (emrs_we_i),
    .emrs_ocd_i  (emrs_ocd_i),
    .emrs_half_i (emrs_half_i),
    .cap_start_i (cap_start_i),
    .dq_i        (dq_i),
    .pu_step_o   (pu_step_o),
    .pd_step_o   (pd_step_o),
    .drv_force_o (drv_force_o),
    .dq_lvl_o    (dq_lvl_o),
    .dqs_lvl_o   (dqs_lvl_o),
    .dqs_n_lvl_o (dqs_n_lvl_o),
    .dflt_ok_o   (dflt_ok_o)
  );

  // {code DT0..DT3, expected pull-up, expected pull-down}, starting from 8/8
  localparam logic [11:0] VEC [13] = '{
    {4'b0001, 4'd9, 4'd8},  {4'b0010, 4'd8, 4'd8},  {4'b0100, 4'd8, 4'd9},
    {4'b1000, 4'd8, 4'd8},  {4'b0101, 4'd9, 4'd9},  {4'b0110, 4'd8, 4'd10},
    {4'b1001, 4'd9, 4'd9},  {4'b1010, 4'd8, 4'd8},  {4'b0000, 4'd8, 4'd8},
    {4'b0011, 4'd8, 4'd8},  {4'b1111, 4'd8, 4'd8},  {4'b1100, 4'd8, 4'd8},
    {4'b0111, 4'd8, 4'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic emrs(input logic [2:0] fld, input logic half);
    @(negedge clk);
    emrs_we_i = 1'b1; emrs_ocd_i = fld; emrs_half_i = half;
    @(negedge clk);
    emrs_we_i = 1'b0;
  endtask

  task automatic send_code(input logic [3:0] c, input logic [3:0] pat);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      cap_start_i = (b == 0);
      dq_i = c[3-b] ? pat : 4'b0;
    end
    @(negedge clk);
    cap_start_i = 1'b0; dq_i = 4'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (sampled during reset)
    chk("R1 pu", pu_step_o, 8);
    chk("R1 pd", pd_step_o, 8);
    chk("R1 force", drv_force_o, 0);
    chk("R1 dflt", dflt_ok_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 lvls", {dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o}, 0);

    // R2 drive high
    emrs(3'b001, 1'b0);
    chk("R2 hi force", drv_force_o, 1);
    chk("R2 hi lvls", {dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o}, 3'b110);
    // R5 reserved keeps drive high
    emrs(3'b101, 1'b0);
    chk("R5 rsv lvls", {drv_force_o, dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o}, 4'b1110);
    // R2 drive low
    emrs(3'b010, 1'b0);
    chk("R2 lo force", drv_force_o, 1);
    chk("R2 lo lvls", {dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o}, 3'b001);
    // R11 strobe outside adjust ignored
    send_code(4'b0001, 4'b1111);
    chk("R11 no adj pu", pu_step_o, 8);
    // R3 exit
    emrs(3'b000, 1'b0);
    chk("R3 exit lvls", {drv_force_o, dq_lvl_o, dqs_lvl_o, dqs_n_lvl_o}, 0);
    chk("R3 exit pu", pu_step_o, 8);

    // R10 adjust clears default flag
    emrs(3'b100, 1'b0);
    chk("R10 adj dflt", dflt_ok_o, 0);

    // R7 / R8 code table
    for (int i = 0; i < 13; i++) begin
      send_code(VEC[i][11:8], 4'b1111);
      chk($sformatf("R7/R8 vec%0d pu", i), pu_step_o, int'(VEC[i][7:4]));
      chk($sformatf("R7/R8 vec%0d pd", i), pd_step_o, int'(VEC[i][3:0]));
    end

    // R6 update edge and lane OR: code 0001, one lane only
    @(negedge clk); cap_start_i = 1'b1; dq_i = 4'b0;
    @(negedge clk); cap_start_i = 1'b0; dq_i = 4'b0;
    @(negedge clk); dq_i = 4'b0;
    @(negedge clk); dq_i = 4'b0010;
    @(negedge clk); dq_i = 4'b0;
    chk("R6 before update", pu_step_o, 8);
    @(negedge clk);
    chk("R6 after update", pu_step_o, 9);
    send_code(4'b1000, 4'b1000);
    chk("R6 lane or pd", pd_step_o, 7);

    // R9 saturation
    for (int i = 0; i < 10; i++) send_code(4'b0101, 4'b1111);
    chk("R9 top pu", pu_step_o, 15);
    chk("R9 top pd", pd_step_o, 15);
    for (int i = 0; i < 17; i++) send_code(4'b1010, 4'b1111);
    chk("R9 bot pu", pu_step_o, 0);
    chk("R9 bot pd", pd_step_o, 0);

    // R3 exit keeps calibrated values
    emrs(3'b000, 1'b0);
    chk("R3 keep pu", pu_step_o, 0);
    chk("R3 keep pd", pd_step_o, 0);
    chk("R10 still low", dflt_ok_o, 0);

    // R4 default load
    emrs(3'b111, 1'b0);
    chk("R4 pu", pu_step_o, 8);
    chk("R4 pd", pd_step_o, 8);
    chk("R4 dflt", dflt_ok_o, 1);

    // R10 half strength
    emrs(3'b000, 1'b1);
    chk("R10 half", dflt_ok_o, 0);
    emrs(3'b000, 1'b0);
    chk("R10 full", dflt_ok_o, 1);

    // R5 reserved in adjust mode
    emrs(3'b100, 1'b0);
    emrs(3'b110, 1'b0);
    chk("R5 rsv pu", pu_step_o, 8);
    send_code(4'b0001, 4'b1111);
    chk("R5 still adj", pu_step_o, 9);

    // R11 abort by EMRS write mid-capture
    @(negedge clk); cap_start_i = 1'b1; dq_i = 4'b0;
    @(negedge clk); cap_start_i = 1'b0;
    @(negedge clk); emrs_we_i = 1'b1; emrs_ocd_i = 3'b100; emrs_half_i = 1'b0;
    @(negedge clk); emrs_we_i = 1'b0; dq_i = 4'b1111;
    @(negedge clk); dq_i = 4'b0;
    repeat (3) @(negedge clk);
    chk("R11 abort pu", pu_step_o, 9);
    chk("R11 abort pd", pd_step_o, 8);

    // R11 strobe during capture ignored
    @(negedge clk); cap_start_i = 1'b1; dq_i = 4'b0;
    @(negedge clk); cap_start_i = 1'b0;
    @(negedge clk); cap_start_i = 1'b1;
    @(negedge clk); cap_start_i = 1'b0; dq_i = 4'b1111;
    @(negedge clk); dq_i = 4'b0;
    repeat (6) @(negedge clk);
    chk("R11 restrobe pu", pu_step_o, 10);
    chk("R11 restrobe pd", pd_step_o, 8);

    summary();
    $finish;
  end

endmodule